// File: doc/BRIEF.md
# Graphics Command Packet Framer

The framer sits between a producer of 32-bit graphics command words (a processor write port or a DMA feeder) and the engines that act on them. The top byte of the first word of each packet is the opcode. From it the block works out how many words the packet holds. It collects that many words and then sends the whole packet onward. Drawing packets and copy packets leave as a beat stream toward the drawing engine. Image-transfer packets become one decoded rectangle toward the transfer engine. Single-word environment packets are written into an eight-entry register file.

Line strips have no fixed length. They end at the first word, in a permitted position, whose nibbles match a sentinel pattern. A strip longer than the packet buffer leaves in several chunks, and only the chunk that holds the sentinel carries the end-of-packet flag.

After a host-to-memory image transfer is announced, the incoming words are no longer parsed as commands. Each word is split into two 16-bit pixels, and this continues until the announced area is covered. Framing then resumes. A 13-bit status field is taken continuously from two of the environment registers.

Top module: `cmd_framer`

## Requirements
- R1: After reset, in_ready is 1, draw_valid, xfer_valid and pix_valid are 0, status_lo is 0, and environment register i reads {5'b11100, i[2:0], 24'h0}.
- R2: Polygon opcodes 0x20–0x3F take a fixed word count set by opcode bits 4:2 (shaded, four-corner, textured). Bits 000 take 4 words, 001 take 7, 010 take 5, 011 take 9, 100 take 6, 101 take 9, 110 take 8 and 111 take 12. Each polygon packet leaves on draw_data in arrival order, with draw_last high only on its final word.
- R3: Opcode 0x02 takes 3 words. Line opcodes 0x40–0x47 take 3 words and 0x50–0x57 take 4. Copy opcodes 0x80–0x9F take 4 words. Rectangle opcodes 0x60–0x7F take 2 words, plus 1 when bit 2 is set, plus 1 when bits 4:3 are 00. Each of these packets is emitted like a polygon.
- R4: Strip opcodes (0x40–0x5F with bit 3 set) end on the first word w with (w & 0xF000F000) == 0x50005000. For opcodes with bit 4 clear, that word's index in the packet must be 3 or more. For opcodes with bit 4 set, the index must be even and 4 or more. A matching word in any other position is an ordinary word. The ending word is emitted with draw_last high.
- R5: A strip longer than BUF_WORDS words leaves in chunks of BUF_WORDS beats with draw_last low. Collection continues without re-reading an opcode, and the word order is kept across chunks.
- R6: Opcodes 0xE0–0xE7 are one-word packets. Each stores its whole word in environment register opcode[2:0], readable on env_rdata through env_sel, and produces no output beat.
- R7: status_lo[10:0] equals environment register 1 bits 10:0, and status_lo[12:11] equals register 6 bits 1:0. These bits change only on the clock edge that accepts an input word.
- R8: Opcodes 0xA0–0xDF take 3 words (command, position, size) and produce one xfer beat. xfer_x is position[9:0] and xfer_y is position[24:16]. xfer_w is ((size[15:0]−1) mod 1024)+1 and xfer_h is ((size[31:16]−1) mod 512)+1. xfer_read is 1 exactly for 0xC0–0xDF.
- R9: After a write transfer (0xA0–0xBF) is accepted, the next input words supply xfer_w×xfer_h pixels on pix_data, the low half of each word first. An unused high half of the final word is dropped. Framing then resumes on the following word.
- R10: While a finished packet waits on draw_ready or xfer_ready, in_ready is 0, the waiting output holds its value, and no two of draw_valid, xfer_valid and pix_valid are high together.
- R11: Opcodes 0x00, 0x01, 0x03–0x1F and 0xE8–0xFF are one-word packets. They are consumed with no output beat and no register change.
- R12: A packet whose words arrive with gaps produces no output beat until its final word has been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word offered |
| in_data | input | 32 | Command or pixel word |
| in_ready | output | 1 | Input word accepted when high with in_valid |
| draw_valid | output | 1 | Drawing beat offered |
| draw_data | output | 32 | Packet word toward the drawing engine |
| draw_last | output | 1 | Final word of a drawing packet |
| draw_ready | input | 1 | Drawing engine takes the beat |
| xfer_valid | output | 1 | Transfer rectangle offered |
| xfer_read | output | 1 | 1 = memory-to-host, 0 = host-to-memory |
| xfer_x | output | 10 | Rectangle left column |
| xfer_y | output | 9 | Rectangle top row |
| xfer_w | output | 11 | Rectangle width, 1 to 1024 |
| xfer_h | output | 10 | Rectangle height, 1 to 512 |
| xfer_ready | input | 1 | Transfer engine takes the rectangle |
| pix_valid | output | 1 | Pixel offered |
| pix_data | output | 16 | Pixel value |
| pix_ready | input | 1 | Pixel sink takes the pixel |
| env_sel | input | 3 | Environment register read select |
| env_rdata | output | 32 | Selected environment register |
| status_lo | output | 13 | Status bits taken from environment registers |

## Verification
The hold assertions assume that each downstream engine, once it has stalled a beat, only ever raises its ready. They do not assume a fixed pattern. The bench drives draw_ready and pix_ready from a pseudo-random sequence, or holds them low on purpose, and never takes a beat back. The status-stability check relies on in_valid being a plain level that the bench raises and lowers only between clock edges. Every input word is offered away from the edge and held until it is accepted.

// File: rtl/cmd_framer.sv
module cmd_framer #(
  parameter int BUF_WORDS = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] in_data,
  output logic        in_ready,
  output logic        draw_valid,
  output logic [31:0] draw_data,
  output logic        draw_last,
  input  logic        draw_ready,
  output logic        xfer_valid,
  output logic        xfer_read,
  output logic [9:0]  xfer_x,
  output logic [8:0]  xfer_y,
  output logic [10:0] xfer_w,
  output logic [9:0]  xfer_h,
  input  logic        xfer_ready,
  output logic        pix_valid,
  output logic [15:0] pix_data,
  input  logic        pix_ready,
  input  logic [2:0]  env_sel,
  output logic [31:0] env_rdata,
  output logic [12:0] status_lo
);
  localparam int CW = $clog2(BUF_WORDS + 1);
  localparam int AW = $clog2(BUF_WORDS);

  typedef enum logic [1:0] {S_COL, S_OUT, S_XFR, S_PIX} st_t;

  st_t           st;
  logic [31:0]   pk [BUF_WORDS];
  logic [31:0]   env [8];
  logic [CW-1:0] cnt, rd;
  logic [7:0]    op_q;
  logic [4:0]    need;
  logic          cont, fin, pe;
  logic [2:0]    pi;
  logic [31:0]   wrd;
  logic          have, half;
  logic [20:0]   left;

  function automatic logic [4:0] plen(input logic [7:0] op);
    logic [4:0] nv;
    nv = op[3] ? 5'd4 : 5'd3;
    if (op == 8'h02) return 5'd3;
    if (op[7:5] == 3'b001) return 5'd1 + (op[2] ? nv + nv : nv) + (op[4] ? nv - 5'd1 : 5'd0);
    if (op[7:5] == 3'b010) return op[3] ? 5'd0 : (op[4] ? 5'd4 : 5'd3);
    if (op[7:5] == 3'b011) return 5'd2 + {4'd0, op[2]} + ((op[4:3] == 2'b00) ? 5'd1 : 5'd0);
    if (op[7:5] == 3'b100) return 5'd4;
    if (op[7:5] == 3'b101 || op[7:5] == 3'b110) return 5'd3;
    return 5'd1;
  endfunction

  wire          hdr     = (cnt == '0) && !cont;
  wire [7:0]    op_c    = hdr ? in_data[31:24] : op_q;
  wire [4:0]    need_c  = hdr ? plen(in_data[31:24]) : need;
  wire          poly    = (op_c[7:5] == 3'b010) && op_c[3];
  wire          img     = (op_c[7:5] == 3'b101) || (op_c[7:5] == 3'b110);
  wire          is_term = (in_data & 32'hF000_F000) == 32'h5000_5000;
  wire          term_ok = op_c[4] ? (pi == 3'd4 && pe) : (pi >= 3'd3);
  wire [CW-1:0] cnt_n   = cnt + 1'b1;
  wire          single  = hdr && need_c == 5'd1;
  wire          done    = poly ? (!hdr && is_term && term_ok) : (32'(cnt_n) == 32'(need_c));
  wire          full    = 32'(cnt_n) == BUF_WORDS;
  wire          at_end  = rd == cnt - 1'b1;
  wire          wr_pk   = st == S_COL && in_valid && !single;

  assign in_ready   = st == S_COL || (st == S_PIX && !have);
  assign draw_valid = st == S_OUT;
  assign draw_data  = pk[rd[AW-1:0]];
  assign draw_last  = fin && at_end;
  assign xfer_valid = st == S_XFR;
  assign xfer_read  = op_q[7:5] == 3'b110;
  assign xfer_x     = pk[1][9:0];
  assign xfer_y     = pk[1][24:16];
  assign xfer_w     = {1'b0, pk[2][9:0] - 10'd1} + 11'd1;
  assign xfer_h     = {1'b0, pk[2][24:16] - 9'd1} + 10'd1;
  assign pix_valid  = st == S_PIX && have;
  assign pix_data   = half ? wrd[31:16] : wrd[15:0];
  assign env_rdata  = env[env_sel];
  assign status_lo  = {env[6][1:0], env[1][10:0]};

  always_ff @(posedge clk) begin
    if (wr_pk) pk[cnt[AW-1:0]] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_COL;
      cnt  <= '0;
      rd   <= '0;
      op_q <= '0;
      need <= '0;
      cont <= 1'b0;
      fin  <= 1'b0;
      pi   <= '0;
      pe   <= 1'b0;
      wrd  <= '0;
      have <= 1'b0;
      half <= 1'b0;
      left <= '0;
      for (int i = 0; i < 8; i++) env[i] <= {5'b11100, 3'(i), 24'd0};
    end else begin
      case (st)
        S_COL: if (in_valid) begin
          if (single) begin
            if (in_data[31:27] == 5'b11100) env[in_data[26:24]] <= in_data;
          end else begin
            cnt <= cnt_n;
            if (hdr) begin
              op_q <= in_data[31:24];
              need <= need_c;
              pi   <= 3'd1;
              pe   <= 1'b0;
            end else begin
              pi <= (pi == 3'd4) ? pi : pi + 3'd1;
              pe <= ~pe;
            end
            if (done) begin
              st  <= img ? S_XFR : S_OUT;
              fin <= 1'b1;
              rd  <= '0;
            end else if (poly && full) begin
              st   <= S_OUT;
              fin  <= 1'b0;
              rd   <= '0;
              cont <= 1'b1;
            end
          end
        end
        S_OUT: if (draw_ready) begin
          if (at_end) begin
            st  <= S_COL;
            cnt <= '0;
            if (fin) cont <= 1'b0;
          end else begin
            rd <= rd + 1'b1;
          end
        end
        S_XFR: if (xfer_ready) begin
          cnt <= '0;
          if (xfer_read) begin
            st <= S_COL;
          end else begin
            st   <= S_PIX;
            left <= 21'(xfer_w) * 21'(xfer_h);
            have <= 1'b0;
          end
        end
        S_PIX: begin
          if (!have) begin
            if (in_valid) begin
              wrd  <= in_data;
              have <= 1'b1;
              half <= 1'b0;
            end
          end else if (pix_ready) begin
            left <= left - 21'd1;
            if (left == 21'd1) begin
              have <= 1'b0;
              st   <= S_COL;
            end else if (half) begin
              have <= 1'b0;
            end else begin
              half <= 1'b1;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/cmd_framer_chk.sv
module cmd_framer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        draw_valid,
  input logic [31:0] draw_data,
  input logic        draw_last,
  input logic        draw_ready,
  input logic        xfer_valid,
  input logic        xfer_read,
  input logic [9:0]  xfer_x,
  input logic [8:0]  xfer_y,
  input logic [10:0] xfer_w,
  input logic [9:0]  xfer_h,
  input logic        xfer_ready,
  input logic        pix_valid,
  input logic [15:0] pix_data,
  input logic        pix_ready,
  input logic [12:0] status_lo
);
  assert_draw_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    draw_valid && !draw_ready |=> draw_valid && $stable(draw_data) && $stable(draw_last));

  assert_xfer_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid && !xfer_ready |=> xfer_valid && $stable({xfer_read, xfer_x, xfer_y, xfer_w, xfer_h}));

  assert_pix_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && !pix_ready |=> pix_valid && $stable(pix_data));

  assert_one_output_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({draw_valid, xfer_valid, pix_valid}));

  assert_stall_input_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (draw_valid || xfer_valid) |-> !in_ready);

  assert_status_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> $stable(status_lo));

  assert_xfer_size_R8: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> xfer_w != 11'd0 && xfer_w <= 11'd1024 && xfer_h != 10'd0 && xfer_h <= 10'd512);
endmodule

bind cmd_framer cmd_framer_chk chk_i (.*);

// File: tb/cmd_framer_tb_top.sv
`timescale 1ns/1ps
module cmd_framer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] in_data;
  logic        in_ready;
  logic        draw_valid, draw_last, draw_ready;
  logic [31:0] draw_data;
  logic        xfer_valid, xfer_read, xfer_ready;
  logic [9:0]  xfer_x;
  logic [8:0]  xfer_y;
  logic [10:0] xfer_w;
  logic [9:0]  xfer_h;
  logic        pix_valid, pix_ready;
  logic [15:0] pix_data;
  logic [2:0]  env_sel;
  logic [31:0] env_rdata;
  logic [12:0] status_lo;

  always #4 clk = ~clk;

  cmd_framer dut_i (.*);

  int total = 0, fails = 0, cyc = 0;
  logic [31:0] dbuf [0:2047];
  logic        dlst [0:2047];
  logic [15:0] pbuf [0:2047];
  int dcnt = 0, pcnt = 0, xcnt = 0;
  logic        xr_read;
  logic [9:0]  xr_x;
  logic [8:0]  xr_y;
  logic [10:0] xr_w;
  logic [9:0]  xr_h;
  logic [31:0] pw [0:63];
  logic [15:0] lfsr = 16'hACE1;
  int mode = 1;

  always @(negedge clk) begin
    if (draw_valid && draw_ready) begin
      dbuf[dcnt & 2047] = draw_data; dlst[dcnt & 2047] = draw_last; dcnt++;
    end
    if (xfer_valid && xfer_ready) begin
      xr_read = xfer_read; xr_x = xfer_x; xr_y = xfer_y; xr_w = xfer_w; xr_h = xfer_h; xcnt++;
    end
    if (pix_valid && pix_ready) begin
      pbuf[pcnt & 2047] = pix_data; pcnt++;
    end
  end

  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    draw_ready = (mode == 0) ? 1'b1 : (mode == 1) ? lfsr[0] : 1'b0;
    pix_ready  = lfsr[3] | lfsr[5];
  end

  task automatic summary;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      total++; fails++;
      $display("FAIL watchdog: got %0d cycles expected completion earlier", cyc);
      summary();
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] w);
    in_valid = 1'b1; in_data = w;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send_pw(input int n);
    for (int k = 0; k < n; k++) send(pw[k]);
  endtask

  task automatic check_pkt(input string req, input int start, input int n);
    int mi;
    idle(60 + 8 * n);
    chk(dcnt - start == n, req, "beat count", dcnt - start, n);
    mi = -1;
    for (int k = 0; k < n; k++)
      if (mi < 0 && (dbuf[(start + k) & 2047] !== pw[k] || dlst[(start + k) & 2047] !== (k == n - 1))) mi = k;
    chk(mi < 0, req, "beat data or last flag", (mi < 0) ? 0 : {dlst[(start + mi) & 2047], dbuf[(start + mi) & 2047]},
        (mi < 0) ? 0 : {(mi == n - 1), pw[mi]});
  endtask

  function automatic int exp_len(input logic [7:0] op);
    if (op == 8'h02) return 3;
    if (op >= 8'h20 && op <= 8'h3F)
      case (op[4:2])
        3'd0: return 4;  3'd1: return 7;  3'd2: return 5;  3'd3: return 9;
        3'd4: return 6;  3'd5: return 9;  3'd6: return 8;  default: return 12;
      endcase
    if (op >= 8'h40 && op <= 8'h5F) return op[3] ? 0 : (op[4] ? 4 : 3);
    if (op >= 8'h60 && op <= 8'h7F)
      case (op[4:2])
        3'd0: return 3;  3'd1: return 4;  3'd2: return 2;  3'd3: return 3;
        3'd4: return 2;  3'd5: return 3;  3'd6: return 2;  default: return 3;
      endcase
    if (op >= 8'h80 && op <= 8'h9F) return 4;
    if (op >= 8'hA0 && op <= 8'hDF) return 0;
    return 1;
  endfunction

  task automatic mk_fixed(input logic [7:0] op, input int n);
    for (int k = 0; k < n; k++)
      pw[k] = (k == 0) ? {op, 8'h5A, op, 8'h00} : {4'h0, 4'(k), 8'h3C, op, 8'(k)};
  endtask

  task automatic check_pixels(input string req, input int start, input int n);
    int mi;
    idle(40);
    chk(pcnt - start == n, req, "pixel count", pcnt - start, n);
    mi = -1;
    for (int k = 0; k < n; k++)
      if (mi < 0 && pbuf[(start + k) & 2047] !== 16'(k)) mi = k;
    chk(mi < 0, req, "pixel order", (mi < 0) ? 0 : pbuf[(start + mi) & 2047], (mi < 0) ? 0 : mi);
  endtask

  logic [31:0] ev [0:7];

  initial begin
    int s, ps, xs, n;
    logic [12:0] exp_st;
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; xfer_ready = 1'b1; env_sel = '0;
    draw_ready = 1'b1; pix_ready = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk({in_ready, draw_valid, xfer_valid, pix_valid} == 4'b1000, "R1", "handshake outputs",
        {in_ready, draw_valid, xfer_valid, pix_valid}, 4'b1000);
    chk(status_lo == 13'd0, "R1", "status", status_lo, 0);
    for (int i = 0; i < 8; i++) begin
      env_sel = 3'(i); #1;
      chk(env_rdata == {5'b11100, 3'(i), 24'd0}, "R1", "env reset value", env_rdata, {5'b11100, 3'(i), 24'd0});
    end
    @(posedge clk); #1;

    // R2, R3: sweep all fixed-length drawing opcodes
    for (int op = 0; op < 256; op++) begin
      n = exp_len(8'(op));
      if (n > 1) begin
        mk_fixed(8'(op), n);
        s = dcnt;
        send_pw(n);
        check_pkt((op >= 8'h20 && op <= 8'h3F) ? "R2" : "R3", s, n);
      end
    end

    // R11: dropped single-word opcodes
    s = dcnt; xs = xcnt; exp_st = status_lo;
    for (int op = 0; op < 256; op++)
      if (exp_len(8'(op)) == 1 && !(op >= 8'hE0 && op <= 8'hE7)) send({8'(op), 24'h12_3456});
    idle(20);
    chk(dcnt == s && xcnt == xs, "R11", "beats from dropped words", dcnt - s + xcnt - xs, 0);
    chk(status_lo == exp_st, "R11", "status after dropped words", status_lo, exp_st);
    env_sel = 3'd3; #1;
    chk(env_rdata == 32'hE300_0000, "R11", "env untouched", env_rdata, 32'hE300_0000);
    mk_fixed(8'h02, 3); s = dcnt; send_pw(3);
    check_pkt("R11", s, 3);

    // R6, R7: environment writes
    s = dcnt;
    for (int i = 0; i < 8; i++) begin
      ev[i] = {5'b11100, 3'(i), 24'(32'h5A3 + i * 32'h10203)};
      send(ev[i]);
    end
    exp_st = {ev[6][1:0], ev[1][10:0]};
    chk(status_lo == exp_st, "R7", "status from env", status_lo, exp_st);
    for (int i = 0; i < 8; i++) begin
      env_sel = 3'(i); #1;
      chk(env_rdata == ev[i], "R6", "env register", env_rdata, ev[i]);
    end
    idle(10);
    chk(dcnt == s, "R6", "no beats from env writes", dcnt - s, 0);
    send(32'hE100_07FF);
    exp_st = {ev[6][1:0], 11'h7FF};
    chk(status_lo == exp_st, "R7", "status after second write", status_lo, exp_st);
    send(32'hE6FF_FFFC);
    exp_st = {2'b00, 11'h7FF};
    chk(status_lo == exp_st, "R7", "status bits 12:11", status_lo, exp_st);

    // R4: strip terminators
    pw[0] = 32'h4800_0001; pw[1] = 32'h0010_0020; pw[2] = 32'h5123_5456;
    pw[3] = 32'h0010_0023; pw[4] = 32'h5FFF_5000;
    s = dcnt; send_pw(5); check_pkt("R4", s, 5);
    pw[0] = 32'h4A00_0000; pw[1] = 32'h0010_0021; pw[2] = 32'h0010_0022; pw[3] = 32'h5555_5555;
    s = dcnt; send_pw(4); check_pkt("R4", s, 4);
    pw[0] = 32'h5800_0000; pw[1] = 32'h0010_0021; pw[2] = 32'h0010_0022;
    pw[3] = 32'h5000_5000; pw[4] = 32'h5001_5002;
    s = dcnt; send_pw(5); check_pkt("R4", s, 5);
    pw[0] = 32'h5C00_0000; pw[1] = 32'h0010_0021; pw[2] = 32'h0010_0022; pw[3] = 32'h0010_0023;
    pw[4] = 32'h0010_0024; pw[5] = 32'h5000_5000; pw[6] = 32'h5AAA_5BBB;
    s = dcnt; send_pw(7); check_pkt("R4", s, 7);

    // R5: strip longer than the buffer
    pw[0] = 32'h4C00_0000;
    for (int k = 1; k <= 20; k++) pw[k] = 32'h0020_0000 + k;
    pw[21] = 32'h5000_5000;
    s = dcnt; send_pw(22); check_pkt("R5", s, 22);

    // R12: gaps between words
    mk_fixed(8'h2C, 9); s = dcnt;
    for (int k = 0; k < 8; k++) begin send(pw[k]); idle(6); end
    chk(dcnt == s && !draw_valid, "R12", "beats before final word", dcnt - s, 0);
    send(pw[8]); check_pkt("R12", s, 9);

    // R10: drawing stall
    mode = 2; mk_fixed(8'h60, 3); s = dcnt; send_pw(3); idle(5);
    @(negedge clk);
    chk(draw_valid && !in_ready && draw_data == pw[0] && dcnt == s, "R10", "draw stall state",
        {draw_valid, in_ready, draw_data}, {2'b10, pw[0]});
    @(posedge clk); #1;
    mode = 1; check_pkt("R10", s, 3);

    // R8, R9: write transfer with odd pixel count, then resume framing
    xs = xcnt; ps = pcnt;
    send(32'hA300_0000); send(32'hFE23_F845); send(32'h0203_0C03);
    for (int j = 0; j < 5; j++) send({16'(2 * j + 1), 16'(2 * j)});
    mk_fixed(8'h02, 3); s = dcnt; send_pw(3);
    check_pixels("R9", ps, 9);
    chk(xcnt - xs == 1 && xr_read == 1'b0, "R8", "write transfer beat", {xcnt - xs, xr_read}, 2);
    chk(xr_x == 10'h045 && xr_y == 9'h023, "R8", "position fields", {xr_x, xr_y}, {10'h045, 9'h023});
    chk(xr_w == 11'd3 && xr_h == 10'd3, "R8", "size fields", {xr_w, xr_h}, {11'd3, 10'd3});
    check_pkt("R9", s, 3);

    // R8, R9: width field zero means 1024
    xs = xcnt; ps = pcnt;
    send(32'hBF00_0000); send(32'h0000_0000); send(32'h0001_0000);
    for (int j = 0; j < 512; j++) send({16'(2 * j + 1), 16'(2 * j)});
    check_pixels("R9", ps, 1024);
    chk(xr_w == 11'd1024 && xr_h == 10'd1, "R8", "maximum width", {xr_w, xr_h}, {11'd1024, 10'd1});

    // R8: read transfer, height field zero means 512, no pixels
    xs = xcnt; ps = pcnt;
    send(32'hC700_0000); send(32'h0000_0000); send(32'h0000_0001);
    mk_fixed(8'h20, 4); s = dcnt; send_pw(4);
    check_pkt("R8", s, 4);
    chk(xcnt - xs == 1 && xr_read && xr_w == 11'd1 && xr_h == 10'd512, "R8", "read transfer fields",
        {xr_read, xr_w, xr_h}, {1'b1, 11'd1, 10'd512});
    chk(pcnt == ps, "R8", "no pixels on read", pcnt - ps, 0);

    // R10: transfer stall
    xfer_ready = 1'b0; xs = xcnt;
    send(32'hD000_0000); send(32'h0001_0002); send(32'h0001_0001);
    idle(5);
    @(negedge clk);
    chk(xfer_valid && !in_ready && xcnt == xs, "R10", "transfer stall state", {xfer_valid, in_ready}, 2'b10);
    @(posedge clk); #1;
    xfer_ready = 1'b1; idle(5);
    chk(xcnt - xs == 1 && in_ready, "R10", "transfer released", xcnt - xs, 1);

    summary();
  end
endmodule